// File: doc/BRIEF.md
# Bidirectional Shift-Latch Display Driver

This block is the logic core of a 32-output display segment driver. A host sends serial data one bit per falling edge of a slow serial clock. Each device has two serial pins, and a direction select chooses which pin takes data in and which passes the far-end stage on to the next device. A chain of devices can therefore be filled from either end. The 32-stage register feeds a bank of output latches. While the strobe is high the latches follow the register, and while it is low they hold their value. A blank input drives every segment output low without touching the stored data.

The serial clock, direction, both serial inputs, strobe and blank are sampled in a fast system clock domain through a two-flop synchronizer. All of them pass through the same pipeline, so the data and the clock edge stay aligned. A falling edge of the synchronized serial clock acts as a one-cycle shift enable. Each bidirectional pin appears as a separate input, output and output-enable signal.

Top module: `seg_shift_driver`

## Requirements
- R1: After reset (rst_ni low) every stage and every latch bit is zero. seg_o reads 0, and both serial outputs read 0.
- R2: With dir_i = 1 (right shift), each serial clock fall moves a_i into stage 1 and stage k into stage k+1. b_o shows stage 32, and seg_o bit n-1 shows stage n.
- R3: With dir_i = 0 (left shift), each serial clock fall moves b_i into stage 32 and stage k+1 into stage k. a_o shows stage 1.
- R4: The register changes only on a falling edge of sclk_i. A rising edge, or sclk_i held at either level, leaves it unchanged.
- R5: While strobe_i is high the latches follow the register, so shifted data reaches seg_o without any further action.
- R6: While strobe_i is low the latches keep the value they held when strobe fell. Shifting then has no effect on seg_o.
- R7: While blank_i is high seg_o is all zeros. When blank falls, seg_o again shows the latch contents, which blanking leaves unchanged.
- R8: The output enable is asserted only on the pin acting as serial output. When dir_i = 1, b_oe_o = 1 and a_oe_o = 0. When dir_i = 0, a_oe_o = 1 and b_oe_o = 0.
- R9: A change of dir_i does not alter stored data. It takes effect at the next serial clock fall.
- R10: When b_o feeds the next device's a_i, and that device's a_o feeds back into b_i, two devices act as one 64-stage register in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than sclk_i |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock; shifting happens on its falling edge |
| dir_i | input | 1 | 1: A is the serial input and B the output; 0: the reverse |
| a_i | input | 1 | Pin A input value |
| a_o | output | 1 | Pin A output value (stage 1) |
| a_oe_o | output | 1 | Pin A output enable |
| b_i | input | 1 | Pin B input value |
| b_o | output | 1 | Pin B output value (stage 32) |
| b_oe_o | output | 1 | Pin B output enable |
| strobe_i | input | 1 | Latch strobe: high makes the latches transparent, low holds them |
| blank_i | input | 1 | High forces all segment outputs low |
| seg_o | output | 32 | Segment outputs; bit n-1 is stage n |

## Verification
A wrong stage value in the register reaches the ports in two ways. It appears on seg_o at the next strobe, and after at most 32 further serial clock falls it reaches the serial output pin. Using two cascaded devices exposes any misrouted or dropped bit at the second device's outputs, and it also exposes any bit in the wrong position. A latch that wrongly follows the register with strobe low shows on seg_o within a few system clocks of the next shift. A stuck blank, or a blank that clears the latch, shows the moment blank is released.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } dir_e;
endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/seg_shreg.sv
module seg_shreg
  import disp_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  dir_e         dir_i,
  input  logic         ser_a_i,
  input  logic         ser_b_i,
  output logic [N-1:0] par_o
);
  logic [N-1:0] sr_q;

  // bit 0 is stage 1, bit N-1 is stage N
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               sr_q <= '0;
    else if (fall_i) begin
      if (dir_i == DIR_RIGHT)  sr_q <= {sr_q[N-2:0], ser_a_i};
      else                     sr_q <= {ser_b_i, sr_q[N-1:1]};
    end
  end

  assign par_o = sr_q;

  AST_RIGHT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && dir_i == DIR_RIGHT |=> sr_q[0] == $past(ser_a_i)); // R2
  AST_RIGHT_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && dir_i == DIR_RIGHT |=> sr_q[N-1:1] == $past(sr_q[N-2:0])); // R2
  AST_LEFT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && dir_i == DIR_LEFT |=> sr_q[N-1] == $past(ser_b_i)); // R3
  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sr_q)); // R4
endmodule

// File: rtl/seg_latch.sv
module seg_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic         blank_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] seg_o
);
  logic [N-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= '0;
    else if (strobe_i) lat_q <= d_i;
  end

  assign seg_o = blank_i ? '0 : lat_q;

  AST_LATCH_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> lat_q == $past(d_i)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(lat_q)); // R6
endmodule

// File: rtl/seg_shift_driver.sv
module seg_shift_driver
  import disp_pkg::*;
#(
  parameter int unsigned N          = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         dir_i,
  input  logic         a_i,
  output logic         a_o,
  output logic         a_oe_o,
  input  logic         b_i,
  output logic         b_o,
  output logic         b_oe_o,
  input  logic         strobe_i,
  input  logic         blank_i,
  output logic [N-1:0] seg_o
);
  localparam int unsigned SW = 6;

  logic [SW-1:0] raw, syn;
  logic          sclk_s, dir_s, a_s, b_s, strobe_s, blank_s;
  logic          sclk_d, fall;
  logic [N-1:0]  stages;
  dir_e          dir_e_s;

  // data travels with the clock so both stay aligned
  assign raw = {blank_i, strobe_i, b_i, a_i, dir_i, sclk_i};

  seg_sync #(.W(SW), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {blank_s, strobe_s, b_s, a_s, dir_s, sclk_s} = syn;
  assign dir_e_s = dir_e'(dir_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign fall = sclk_d & ~sclk_s;

  seg_shreg #(.N(N)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall),
    .dir_i  (dir_e_s),
    .ser_a_i(a_s),
    .ser_b_i(b_s),
    .par_o  (stages)
  );

  seg_latch #(.N(N)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_s),
    .blank_i (blank_s),
    .d_i     (stages),
    .seg_o   (seg_o)
  );

  assign a_o    = stages[0];
  assign b_o    = stages[N-1];
  assign a_oe_o = (dir_e_s == DIR_LEFT);
  assign b_oe_o = (dir_e_s == DIR_RIGHT);

  AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_o ^ b_oe_o); // R8
  AST_BLANK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_s |-> seg_o == '0); // R7
endmodule

// File: tb/seg_shift_driver_test.sv
module seg_shift_driver_test;
  localparam int N = 32;

  logic clk = 0, rst_ni = 0;
  logic sclk = 0, dir = 1, strobe = 0, blank = 0;
  logic host_a = 0, host_b = 0;
  logic a1_o, a1_oe, b1_o, b1_oe, a2_o, a2_oe, b2_o, b2_oe;
  logic [N-1:0] seg1, seg2;

  logic [63:0] chain_m = '0;
  logic [63:0] lat_m   = '0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  seg_shift_driver uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .dir_i(dir),
    .a_i(host_a), .a_o(a1_o), .a_oe_o(a1_oe),
    .b_i(a2_o), .b_o(b1_o), .b_oe_o(b1_oe),
    .strobe_i(strobe), .blank_i(blank), .seg_o(seg1)
  );

  seg_shift_driver uut2 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .dir_i(dir),
    .a_i(b1_o), .a_o(a2_o), .a_oe_o(a2_oe),
    .b_i(host_b), .b_o(b2_o), .b_oe_o(b2_oe),
    .strobe_i(strobe), .blank_i(blank), .seg_o(seg2)
  );

  function automatic logic [63:0] shift_model(logic [63:0] c, logic d, logic bit_in);
    return d ? {c[62:0], bit_in} : {bit_in, c[63:1]};
  endfunction

  function automatic logic [63:0] seg_model(logic [63:0] l, logic blk);
    return blk ? 64'd0 : l;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_bit(logic bit_in);
    if (dir) host_a = bit_in; else host_b = bit_in;
    sclk = 1;
    wait_clk(4);
    sclk = 0;
    wait_clk(4);
    chain_m = shift_model(chain_m, dir, bit_in);
  endtask

  task automatic pulse_strobe();
    strobe = 1;
    wait_clk(5);
    strobe = 0;
    wait_clk(5);
    lat_m = chain_m;
  endtask

  task automatic check_segs(string tag);
    check(tag, {seg2, seg1}, seg_model(lat_m, blank));
  endtask

  initial begin
    automatic int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    wait_clk(3);
    check("R1 reset segs", {seg2, seg1}, 64'd0);
    check("R1 reset serial", {62'd0, b1_o, a1_o}, 64'd0);
    rst_ni = 1;
    wait_clk(4);

    // right shift through the cascade
    dir = 1;
    wait_clk(4);
    check("R8 right oe", {60'd0, a1_oe, b1_oe, a2_oe, b2_oe}, 64'b0101);
    for (int i = 0; i < 64; i++) shift_bit(1'($urandom));
    check("R6 no strobe held", {seg2, seg1}, 64'd0);
    pulse_strobe();
    check_segs("R2 R10 right cascade");
    check("R2 b_o stage32", {63'd0, b2_o}, {63'd0, chain_m[63]});

    // R4: rising edge only, then strobe
    sclk = 1; host_a = ~host_a;
    wait_clk(6);
    pulse_strobe();
    check_segs("R4 rise no shift");
    sclk = 0;
    wait_clk(4);
    chain_m = shift_model(chain_m, dir, host_a);

    // R5: transparent strobe follows shifts
    strobe = 1;
    wait_clk(4);
    for (int i = 0; i < 5; i++) shift_bit(1'($urandom));
    wait_clk(2);
    lat_m = chain_m;
    check_segs("R5 transparent");
    strobe = 0;
    wait_clk(5);

    // R6: shifting with strobe low
    for (int i = 0; i < 7; i++) shift_bit(1'($urandom));
    check_segs("R6 hold while shifting");

    // R7: blank
    blank = 1;
    wait_clk(4);
    check("R7 blank dark", {seg2, seg1}, 64'd0);
    pulse_strobe();
    check("R7 blank dark after strobe", {seg2, seg1}, 64'd0);
    blank = 0;
    wait_clk(4);
    check_segs("R7 release restores");

    // R9: dir change keeps data
    dir = 0;
    wait_clk(5);
    pulse_strobe();
    check_segs("R9 dir change keeps data");
    check("R8 left oe", {60'd0, a1_oe, b1_oe, a2_oe, b2_oe}, 64'b1010);

    // left shift through the cascade
    for (int i = 0; i < 64; i++) shift_bit(1'($urandom));
    pulse_strobe();
    check_segs("R3 R10 left cascade");
    check("R3 a_o stage1", {63'd0, a1_o}, {63'd0, chain_m[0]});

    // random rounds in both directions
    for (int r = 0; r < 6; r++) begin
      dir = 1'($urandom);
      wait_clk(4);
      for (int i = 0; i < 8 + int'($urandom_range(0, 40)); i++) shift_bit(1'($urandom));
      pulse_strobe();
      check_segs(dir ? "R2 random right" : "R3 random left");
      blank = 1'($urandom);
      wait_clk(4);
      check_segs("R7 random blank");
      blank = 0;
      wait_clk(4);
    end

    // directed corners: all ones right, then zeros left
    dir = 1;
    wait_clk(4);
    for (int i = 0; i < 64; i++) shift_bit(1'b1);
    pulse_strobe();
    check_segs("R2 all ones");
    dir = 0;
    wait_clk(4);
    shift_bit(1'b0);
    pulse_strobe();
    check_segs("R3 single zero at top");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule